// File: doc/BRIEF.md
# Debug TAP with Instruction and Data Transfer Chains

This block is the target-side end of a JTAG debug link. A 16-state TAP controller drives a 5-bit instruction register and a 5-bit scan-chain select register. Behind them sit three debug chains:

- a 32-bit status/control word;
- an instruction chain that hands a 32-bit opcode to the core;
- a data chain that moves 32-bit words between the host and the core, each direction through its own holding register with a full/empty flag.

The host selects a chain once and then issues instructions by walking the TAP into Run-Test/Idle. A dedicated instruction reaches the instruction chain without rewriting the select register. This lets a debugger alternate between loading opcodes and streaming data words with few IR and select-register scans.

The core side is a simple level handshake. `ins_valid` rises when an instruction is issued and stays high until the core pulses `ins_done`. Host-to-core words are presented on `h2c_data` while `h2c_full` is high, and the core frees the register with `h2c_take`. The core offers words with `c2h_put`, and `c2h_full` reports that the offered word is waiting for the host. Every signal, including the core side, is synchronous to `tck`.

Top module: `dbgx_tap_xfer`

## Requirements
- R1: `trst_n` low at a `tck` edge, or five consecutive `tck` edges with `tms`=1, puts the TAP in Test-Logic-Reset. That state loads the bypass instruction 0x1F and clears the select register to 0. The bypass chain is 1 bit and captures 0. An IR scan captures 5'b00001, and `trst_n` low also clears all core-side flags.
- R2: Under instruction 0x02 a DR scan addresses the 5-bit select register, which captures 0x10. The shifted value becomes the selected chain at Update-DR and at no other time.
- R3: With select value 1, a DR scan reaches the 32-bit status word. It is written at Update-DR under EXTEST (0x00) and only read under INTEST (0x0C).
- R4: The instruction chain is 33 bits: opcode in bits 31:0 (bit 0 shifted first) and a completion flag in bit 32. The flag captures 1 when no issued instruction is outstanding, and bit 31:0 captures the held opcode.
- R5: With the select register at 4 or 5 and INTEST, EXTEST or 0x1D in the IR, each entry into Run-Test/Idle raises `ins_valid` once, carrying the held opcode on `ins_word`. Remaining in Run-Test/Idle does not issue again.
- R6: Instruction 0x1D routes DR scans to the instruction chain, and its updates leave the select register unchanged.
- R7: When the select register is 0, entering Run-Test/Idle issues no instruction.
- R8: With select value 5 under EXTEST, the 34-bit data chain is laid out as follows: bits 31:0 data, bit 32 Ready, bit 33 nRetry. nRetry always captures 1, and Ready captures 1 when the host-to-core register is empty. At Update-DR the word is committed (`h2c_full` set) only if Ready was captured as 1.
- R9: With select value 5 under INTEST, the data chain captures the core-to-host word and Ready = `c2h_full`. A capture while full clears `c2h_full`, and `c2h_put` while full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, the only clock |
| trst_n | input | 1 | Synchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (LSB of the active shift register) |
| ins_valid | output | 1 | Issued instruction outstanding |
| ins_word | output | 32 | Opcode for the core |
| ins_done | input | 1 | Core completion pulse |
| h2c_data | output | 32 | Host-to-core data word |
| h2c_full | output | 1 | Host-to-core register holds a word |
| h2c_take | input | 1 | Core consumes the host-to-core word |
| c2h_word | input | 32 | Core-to-host data offered by the core |
| c2h_put | input | 1 | Core writes `c2h_word` |
| c2h_full | output | 1 | Core-to-host register holds unread data |

## Verification
Every TAP step in the bench is one `tck` edge, and all outputs are read at the following falling edge.

- Captured values are compared bit by bit as they appear on `tdo` during Shift.
- A word committed at Update-DR is visible on `h2c_data` and `h2c_full` one edge after the Update state.
- `ins_valid` rises on the second edge after the TAP enters Run-Test/Idle, so the bench idles one extra cycle before looking for an issue.
- A bench model counts issues at every falling edge and records each issued opcode. Those counts are compared with the number of idle entries the stimulus made under an enabling selection.

// File: rtl/dbgx_pkg.sv
// Shared widths, TAP state encoding, instruction codes and chain identifiers.
package dbgx_pkg;
    localparam int IR_W  = 5;
    localparam int SEL_W = 5;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_st_t;

    localparam logic [IR_W-1:0] OP_EXTEST   = 5'h00;
    localparam logic [IR_W-1:0] OP_SCAN_SEL = 5'h02;
    localparam logic [IR_W-1:0] OP_INTEST   = 5'h0C;
    localparam logic [IR_W-1:0] OP_ITR      = 5'h1D;
    localparam logic [IR_W-1:0] OP_BYPASS   = 5'h1F;

    localparam logic [SEL_W-1:0] SEL_STAT = 5'd1;
    localparam logic [SEL_W-1:0] SEL_INS  = 5'd4;
    localparam logic [SEL_W-1:0] SEL_DATA = 5'd5;
    localparam logic [SEL_W-1:0] SEL_MARK = {1'b1, {(SEL_W-1){1'b0}}};

    typedef enum logic [2:0] {CH_BYP, CH_SEL, CH_STAT, CH_INS, CH_DATA} chain_t;
endpackage

// File: rtl/dbgx_tap_ctrl.sv
// TAP controller: the standard 16-state machine clocked by tck.
// Assumes trst_n is synchronous to tck and active low.
module dbgx_tap_ctrl
    import dbgx_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tms,
    output tap_st_t state
);
    tap_st_t nxt;

    // Next-state selection from tms
    always_comb begin
        unique case (state)
            TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            default:   nxt = TS_RESET;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge tck) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= nxt;
    end

    // R1
    five_tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> state == TS_RESET);
endmodule

// File: rtl/dbgx_ir_sel.sv
// Instruction register, scan-chain select register and chain routing.
// Assumes the DR shift register delivers the select field in its low bits.
module dbgx_ir_sel
    import dbgx_pkg::*;
(
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  tap_st_t          state,
    input  logic [SEL_W-1:0] sel_bits,
    output logic [IR_W-1:0]  ir_q,
    output logic [SEL_W-1:0] sel_q,
    output chain_t           chain,
    output logic             exec_ok,
    output logic             ir_tdo
);
    logic [IR_W-1:0] ir_sh;
    logic            ir_dbg;

    assign ir_tdo = ir_sh[0];
    assign ir_dbg = (ir_q == OP_INTEST) || (ir_q == OP_EXTEST) || (ir_q == OP_ITR);

    // IR shift path: capture fixed pattern, shift LSB first
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_sh <= '0;
        else if (state == TS_CAP_IR) ir_sh <= IR_W'(1);
        else if (state == TS_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Instruction register: bypass on reset, loaded at Update-IR
    always_ff @(posedge tck) begin
        if (!trst_n || state == TS_RESET) ir_q <= OP_BYPASS;
        else if (state == TS_UPD_IR)      ir_q <= ir_sh;
    end

    // Select register: cleared on reset, loaded at Update-DR under the select instruction
    always_ff @(posedge tck) begin
        if (!trst_n || state == TS_RESET)                  sel_q <= '0;
        else if (state == TS_UPD_DR && ir_q == OP_SCAN_SEL) sel_q <= sel_bits;
    end

    // Routing of DR scans to one chain
    always_comb begin
        chain = CH_BYP;
        if (ir_q == OP_SCAN_SEL)  chain = CH_SEL;
        else if (ir_q == OP_ITR)  chain = CH_INS;
        else if (ir_dbg) begin
            if (sel_q == SEL_STAT)     chain = CH_STAT;
            else if (sel_q == SEL_INS) chain = CH_INS;
            else if (sel_q == SEL_DATA) chain = CH_DATA;
        end
    end

    // Execution enable: debug instruction plus instruction or data chain selected
    assign exec_ok = ir_dbg && (sel_q == SEL_INS || sel_q == SEL_DATA);

    // R6
    itr_keeps_sel_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_UPD_DR && ir_q == OP_ITR) |=> $stable(sel_q));
    // R2
    sel_update_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(sel_q) |-> ($past(state) == TS_UPD_DR || $past(state) == TS_RESET || !$past(trst_n)));
endmodule

// File: rtl/dbgx_chains.sv
// DR shift register shared by all chains, plus status, instruction issue and
// the two data holding registers with their core-side handshakes.
// Assumes core-side signals are synchronous to tck.
module dbgx_chains
    import dbgx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_st_t           state,
    input  chain_t            chain,
    input  logic [IR_W-1:0]   ir_q,
    input  logic              exec_ok,
    output logic              dr_tdo,
    output logic [SEL_W-1:0]  sel_bits,
    output logic              ins_valid,
    output logic [DATA_W-1:0] ins_word,
    input  logic              ins_done,
    output logic [DATA_W-1:0] h2c_data,
    output logic              h2c_full,
    input  logic              h2c_take,
    input  logic [DATA_W-1:0] c2h_word,
    input  logic              c2h_put,
    output logic              c2h_full
);
    localparam int SH_W  = DATA_W + 2;
    localparam int IDX_W = $clog2(SH_W);

    logic [SH_W-1:0]   dr_sh, sh_nxt, cap_val;
    logic [IDX_W-1:0]  last_idx;
    logic [DATA_W-1:0] status_q, c2h_q;
    logic              rdy_cap, idle_entry;
    tap_st_t           prev_st;
    logic              is_in, is_ex;

    assign is_in    = (ir_q == OP_INTEST);
    assign is_ex    = (ir_q == OP_EXTEST);
    assign dr_tdo   = dr_sh[0];
    assign sel_bits = dr_sh[SEL_W-1:0];

    // Chain length decides where tdi enters
    always_comb begin
        unique case (chain)
            CH_SEL:  last_idx = IDX_W'(SEL_W - 1);
            CH_STAT: last_idx = IDX_W'(DATA_W - 1);
            CH_INS:  last_idx = IDX_W'(DATA_W);
            CH_DATA: last_idx = IDX_W'(DATA_W + 1);
            default: last_idx = '0;
        endcase
    end

    // One shift step: move toward bit 0, tdi at the chain's far end
    always_comb begin
        sh_nxt = dr_sh >> 1;
        sh_nxt[last_idx] = tdi;
    end

    // Values presented at Capture-DR for each chain
    always_comb begin
        cap_val = '0;
        unique case (chain)
            CH_SEL:  cap_val[SEL_W-1:0] = SEL_MARK;
            CH_STAT: cap_val[DATA_W-1:0] = status_q;
            CH_INS:  cap_val[DATA_W:0] = {~ins_valid, ins_word};
            CH_DATA: cap_val = is_in ? {1'b1, c2h_full, c2h_q}
                                     : {1'b1, ~h2c_full, {DATA_W{1'b0}}};
            default: cap_val = '0;
        endcase
    end

    // Shared DR shift register
    always_ff @(posedge tck) begin
        if (!trst_n)                 dr_sh <= '0;
        else if (state == TS_CAP_DR) dr_sh <= cap_val;
        else if (state == TS_SH_DR)  dr_sh <= sh_nxt;
    end

    // Status word: written only under EXTEST
    always_ff @(posedge tck) begin
        if (!trst_n) status_q <= '0;
        else if (state == TS_UPD_DR && chain == CH_STAT && is_ex) status_q <= dr_sh[DATA_W-1:0];
    end

    // Held opcode: written through the instruction chain except under INTEST
    always_ff @(posedge tck) begin
        if (!trst_n) ins_word <= '0;
        else if (state == TS_UPD_DR && chain == CH_INS && !is_in) ins_word <= dr_sh[DATA_W-1:0];
    end

    // Previous TAP state, used to see the first cycle in Run-Test/Idle
    always_ff @(posedge tck) begin
        if (!trst_n) prev_st <= TS_RESET;
        else         prev_st <= state;
    end
    assign idle_entry = (state == TS_IDLE) && (prev_st != TS_IDLE);

    // Issue handshake: raised once per idle entry, dropped on completion
    always_ff @(posedge tck) begin
        if (!trst_n)                     ins_valid <= 1'b0;
        else if (idle_entry && exec_ok)  ins_valid <= 1'b1;
        else if (ins_done)               ins_valid <= 1'b0;
    end

    // Ready seen by the host on an EXTEST data capture
    always_ff @(posedge tck) begin
        if (!trst_n)                 rdy_cap <= 1'b0;
        else if (state == TS_CAP_DR) rdy_cap <= (chain == CH_DATA) && is_ex && !h2c_full;
        else if (state == TS_UPD_DR) rdy_cap <= 1'b0;
    end

    // Host-to-core register: committed at Update-DR only after a Ready capture
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            h2c_full <= 1'b0;
            h2c_data <= '0;
        end else if (state == TS_UPD_DR && rdy_cap) begin
            h2c_full <= 1'b1;
            h2c_data <= dr_sh[DATA_W-1:0];
        end else if (h2c_take) begin
            h2c_full <= 1'b0;
        end
    end

    // Core-to-host register: host capture empties it, core writes only when empty
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            c2h_full <= 1'b0;
            c2h_q    <= '0;
        end else if (state == TS_CAP_DR && chain == CH_DATA && is_in && c2h_full) begin
            c2h_full <= 1'b0;
        end else if (c2h_put && !c2h_full) begin
            c2h_full <= 1'b1;
            c2h_q    <= c2h_word;
        end
    end

    // R5
    no_reissue_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_IDLE && $past(state) == TS_IDLE && !ins_valid) |=> !ins_valid);
    // R3
    status_ro_intest_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (chain == CH_STAT && is_in) |=> $stable(status_q));
    // R8
    h2c_commit_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(h2c_full) |-> $past(state) == TS_UPD_DR);
    // R9
    c2h_drain_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $fell(c2h_full) |-> $past(state) == TS_CAP_DR);
endmodule

// File: rtl/dbgx_tap_xfer.sv
// Top: TAP controller, IR/select logic and debug chains wired together.
// Assumes a single tck domain for host and core sides.
module dbgx_tap_xfer
    import dbgx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              ins_valid,
    output logic [DATA_W-1:0] ins_word,
    input  logic              ins_done,
    output logic [DATA_W-1:0] h2c_data,
    output logic              h2c_full,
    input  logic              h2c_take,
    input  logic [DATA_W-1:0] c2h_word,
    input  logic              c2h_put,
    output logic              c2h_full
);
    tap_st_t          state;
    chain_t           chain;
    logic [IR_W-1:0]  ir_q;
    logic [SEL_W-1:0] sel_q, sel_bits;
    logic             exec_ok, ir_tdo, dr_tdo;

    dbgx_tap_ctrl u_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
    );

    dbgx_ir_sel u_irsel (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .sel_bits(sel_bits),
        .ir_q(ir_q), .sel_q(sel_q), .chain(chain), .exec_ok(exec_ok), .ir_tdo(ir_tdo)
    );

    dbgx_chains #(.DATA_W(DATA_W)) u_chains (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .chain(chain),
        .ir_q(ir_q), .exec_ok(exec_ok), .dr_tdo(dr_tdo), .sel_bits(sel_bits),
        .ins_valid(ins_valid), .ins_word(ins_word), .ins_done(ins_done),
        .h2c_data(h2c_data), .h2c_full(h2c_full), .h2c_take(h2c_take),
        .c2h_word(c2h_word), .c2h_put(c2h_put), .c2h_full(c2h_full)
    );

    // Serial output: IR bit while shifting IR, otherwise the DR bit
    assign tdo = (state == TS_SH_IR) ? ir_tdo : dr_tdo;

    // R7
    issue_needs_sel_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(ins_valid) |-> ($past(sel_q) == SEL_INS || $past(sel_q) == SEL_DATA));
    // R5
    issue_on_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(ins_valid) |-> ($past(state) == TS_IDLE && $past(exec_ok)));
endmodule

// File: tb/dbgx_tap_xfer_test.sv
`timescale 1ns/1ps
module dbgx_tap_xfer_test;
    logic        tck = 0, trst_n = 0, tms = 1, tdi = 0;
    logic        tdo, ins_valid, ins_done = 0, h2c_full, h2c_take = 0, c2h_put = 0, c2h_full;
    logic [31:0] ins_word, h2c_data, c2h_word = 0;

    int n_chk = 0, n_fail = 0, issues = 0;
    bit in_pause = 0, auto_done = 0, fin = 0, last_v = 0;
    logic [31:0] issued_q[$];
    logic [33:0] d;

    always #2 tck = ~tck;

    dbgx_tap_xfer uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .ins_valid(ins_valid), .ins_word(ins_word), .ins_done(ins_done),
        .h2c_data(h2c_data), .h2c_full(h2c_full), .h2c_take(h2c_take),
        .c2h_word(c2h_word), .c2h_put(c2h_put), .c2h_full(c2h_full)
    );

    // Core model: count and record issues, answer completion one cycle later
    initial forever begin
        @(negedge tck);
        if (ins_valid && !last_v) begin
            issues++;
            issued_q.push_back(ins_word);
        end
        last_v = ins_valid;
        ins_done = ins_valid && auto_done;
    end

    task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clk(input bit t);
        tms = t;
        @(posedge tck);
        @(negedge tck);
    endtask

    task automatic scan(input bit is_ir, input int n, input logic [33:0] din,
                        input bit end_idle, output logic [33:0] dout);
        dout = '0;
        if (in_pause) begin clk(1); clk(1); end
        clk(1);
        if (is_ir) clk(1);
        clk(0);
        clk(0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            clk(i == n - 1);
        end
        if (end_idle) begin clk(1); clk(0); in_pause = 0; end
        else begin clk(0); in_pause = 1; end
    endtask

    task automatic flush;
        if (in_pause) begin clk(1); clk(1); clk(0); in_pause = 0; end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) clk(0);
    endtask

    task automatic put(input logic [31:0] w);
        c2h_word = w; c2h_put = 1;
        @(posedge tck); @(negedge tck);
        c2h_put = 0;
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!fin) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge tck);
        trst_n = 1;
        // R1 reset state
        chk("R1 ins_valid", ins_valid, 0);
        chk("R1 h2c_full", h2c_full, 0);
        chk("R1 c2h_full", c2h_full, 0);
        clk(0);
        scan(0, 4, 34'hB, 0, d);            // R1 bypass: 1-bit delay, captures 0
        chk("R1 bypass", d[3:0], 4'b0110);
        scan(1, 5, 34'h02, 0, d);           // R1 IR capture pattern
        chk("R1 ir capture", d[4:0], 5'b00001);
        scan(0, 5, 34'h01, 0, d);           // R2 marker, select chain 1
        chk("R2 marker", d[4:0], 5'h10);
        scan(1, 5, 34'h00, 0, d);
        scan(0, 32, 34'hA5C30F96, 0, d);    // R3 write status
        scan(1, 5, 34'h0C, 0, d);
        scan(0, 32, 34'h0, 0, d);
        chk("R3 status read", d[31:0], 32'hA5C30F96);
        scan(0, 32, 34'h12345678, 0, d);    // INTEST must not write
        chk("R3 intest no write", d[31:0], 32'hA5C30F96);
        // select data chain, then instruction via shortcut
        scan(1, 5, 34'h02, 0, d);
        scan(0, 5, 34'h05, 0, d);
        chk("R2 marker again", d[4:0], 5'h10);
        scan(1, 5, 34'h1D, 0, d);
        scan(0, 33, {2'b00, 32'hE1234567}, 1, d);
        chk("R4 flag idle", d[32], 1);
        chk("R4 opcode capture", d[31:0], 0);
        idle(1);
        chk("R5 issued", ins_valid, 1);
        chk("R6 opcode via shortcut", ins_word, 32'hE1234567);
        idle(5);
        chk("R5 no reissue", issues, 1);
        scan(0, 33, {2'b00, 32'hE1234567}, 0, d);
        chk("R4 flag busy", d[32], 0);
        chk("R4 held opcode", d[31:0], 32'hE1234567);
        auto_done = 1;
        idle(3);
        chk("R4 completed", ins_valid, 0);
        scan(0, 33, {2'b00, 32'hE1234567}, 0, d);
        chk("R4 flag done", d[32], 1);
        // R6/R8: select register still 5, EXTEST reaches the data chain
        scan(1, 5, 34'h00, 0, d);
        scan(0, 34, {2'b00, 32'h0BADF00D}, 0, d);
        chk("R8 ready empty", d[32], 1);
        chk("R8 nretry", d[33], 1);
        scan(0, 34, {2'b00, 32'hDEADDEAD}, 0, d);
        chk("R8 ready full", d[32], 0);
        chk("R8 committed", h2c_data, 32'h0BADF00D);
        chk("R8 full", h2c_full, 1);
        flush;
        chk("R8 no overwrite", h2c_data, 32'h0BADF00D);
        idle(1);
        chk("R5 entry issues", issues, 2);
        chk("R5 issued opcode", issued_q[1], 32'hE1234567);
        h2c_take = 1; @(posedge tck); @(negedge tck); h2c_take = 0;
        chk("R8 take", h2c_full, 0);
        // R9 core-to-host
        put(32'h13579BDF);
        chk("R9 full after put", c2h_full, 1);
        put(32'h2468ACE0);
        scan(1, 5, 34'h0C, 0, d);
        scan(0, 34, 34'h0, 0, d);
        chk("R9 ready", d[32], 1);
        chk("R9 data kept first", d[31:0], 32'h13579BDF);
        chk("R9 drained", c2h_full, 0);
        scan(0, 34, 34'h0, 0, d);
        chk("R9 ready empty", d[32], 0);
        // R7 chain 0 disables issue
        scan(1, 5, 34'h02, 0, d);
        scan(0, 5, 34'h00, 0, d);
        scan(1, 5, 34'h00, 1, d);
        idle(3);
        chk("R7 no issue", issues, 2);
        // R1 five-TMS reset
        scan(1, 5, 34'h02, 0, d);
        scan(0, 5, 34'h01, 0, d);
        scan(1, 5, 34'h0C, 0, d);
        repeat (5) clk(1);
        in_pause = 0;
        clk(0);
        scan(0, 4, 34'hB, 0, d);
        chk("R1 tms reset ir", d[3:0], 4'b0110);
        scan(1, 5, 34'h00, 0, d);
        scan(0, 4, 34'hB, 0, d);
        chk("R1 tms reset sel", d[3:0], 4'b0110);
        // R1 trst clears core-side flags
        put(32'h55AA55AA);
        trst_n = 0; @(posedge tck); @(negedge tck); trst_n = 1;
        chk("R1 trst c2h", c2h_full, 0);
        fin = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule